// File: doc/BRIEF.md
# NAND Operation Word Sequencer

This block turns 32-bit operation words, queued by software through a write at register offset 0, into timed phases on an 8-bit asynchronous NAND bus. Each word is one phase: a command latch, an address latch, a burst of data writes, or a burst of data reads. Write data comes from a byte queue that the DMA engine fills. Read data goes into a byte queue that the DMA engine drains. Strobe low time, strobe high time, the settle gap before ready sampling and the empty-queue timeout are fixed module parameters.

An operation word has these fields:

| Bits | Meaning |
|------|---------|
| 17:16 | Phase type: 0 address, 1 command, 2 data write, 3 data read |
| 19 | Wait for ready |
| 18 | Last cycle (release chip enable) |
| 13 | Raise the interrupt on completion |
| 7:0 | Latched byte (command and address phases) |
| 11:0 | Length minus one (data phases) |

The status word lives at offset 0x118. It is presented on a port. Writing ones to offset 0x120 clears the matching sticky bits.

The sequencer FSM has eight states:

| State | Role |
|-------|------|
| IDLE | Takes the next word from the queue |
| LOAD | Presents the byte; a write phase waits here for transmit data |
| STROBE | WE# or RE# is held low |
| RECOVER | The strobe is held high |
| SETTLE | Fixed gap before ready is sampled |
| RDY | Holds until R/B# is high |
| DONE | Reports completion |
| ABORT | Discards a write phase that starved |

Its transitions are:
- IDLE→LOAD when the queue is not empty.
- LOAD→STROBE when a byte is available.
- LOAD→ABORT on timeout.
- STROBE→RECOVER after the low time.
- RECOVER→LOAD when data bytes remain.
- RECOVER→SETTLE when wait-for-ready is set.
- RECOVER→DONE otherwise.
- SETTLE→RDY after the gap.
- RDY→DONE when ready.
- DONE→IDLE and ABORT→IDLE.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, CE#, WE# and RE# are high, CLE and ALE are low, the status word is 0 and the interrupt is low.
- R2: A command phase (type 1) gives one WE# low pulse of exactly T_LO cycles, with CLE high, ALE low and bits 7:0 on the data bus.
- R3: An address phase (type 0) gives one WE# pulse with ALE high, CLE low and bits 7:0 on the bus.
- R4: A write phase (type 2) with low field L gives L+1 WE# pulses, with CLE and ALE low. The pulses carry successive transmit-queue bytes in the order they were pushed.
- R5: A read phase (type 3) with low field L gives L+1 RE# pulses. Each bus byte is sampled in the last cycle of its low time and pushed into the receive queue. Status bit 3 shows that the queue holds data. Status bit 12 is set when any data phase completes.
- R6: With bit 19 set, completion (status bit 9) is withheld while R/B# is low. Completion follows once R/B# goes high.
- R7: Completion sets sticky status bit 9 exactly 3+T_LO+T_HI cycles after a single-byte command word is pushed without bit 19. A write to 0x120 with bit 9 set clears it.
- R8: A completed word with bit 13 set raises the interrupt output. Clearing status bit 9 drops it.
- R9: CE# goes low when a phase starts. It stays low after a word without bit 18, and returns high once a word with bit 18 completes.
- R10: The word queue holds 8 entries. A push into a full queue is dropped and sets sticky status bit 11.
- R11: A write phase that finds the transmit queue empty for TX_TMO cycles is discarded. It sets status bits 11 and 1, does not set bit 9, and releases CE#.
- R12: Pushing a full transmit queue sets bit 2, and the byte is dropped. Popping an empty receive queue sets bit 4. A read byte arriving at a full receive queue is dropped and sets bit 5.
- R13: Status bit 10 is high while words are queued. Bit 0 is high while a write phase waits for transmit data.
- R14: Words execute in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| int_status | output | 16 | Interrupt status word (offset 0x118) |
| irq | output | 1 | Completion interrupt |
| tx_push | input | 1 | DMA pushes a transmit byte |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | DMA pops a receive byte |
| rx_data | output | 8 | Head of receive queue |
| rx_empty | output | 1 | Receive queue empty |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from the flash |
| nand_rb_n | input | 1 | Ready/busy, high when ready |

## Verification
The first strobe of a word falls two cycles after the push edge. Completion lands 3+T_LO+T_HI cycles after the push for a single-byte word without wait-for-ready. The bench samples at falling edges, checks that window exactly once, one cycle early and on time, and otherwise polls completion with a bounded count. Strobe widths and bus contents are captured by a monitor that counts low cycles per pulse and compares them, once the word finishes, against lists built by bench functions. Ready-gated, timeout and overflow results are checked only after waits well beyond their fixed windows, so the results never race the edge.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;

    localparam int LEN_W    = 12;
    localparam int STAT_W   = 16;

    localparam int TYPE_LSB = 16;
    localparam int BIT_WFR  = 19;
    localparam int BIT_LC   = 18;
    localparam int BIT_IWC  = 13;

    localparam int ST_DREQ  = 0;
    localparam int ST_TXUF  = 1;
    localparam int ST_TXOF  = 2;
    localparam int ST_DAV   = 3;
    localparam int ST_RXUF  = 4;
    localparam int ST_RXOF  = 5;
    localparam int ST_DONE  = 9;
    localparam int ST_CAV   = 10;
    localparam int ST_ERR   = 11;
    localparam int ST_XOVER = 12;

    localparam logic [9:0] OFS_QUEUE = 10'h000;
    localparam logic [9:0] OFS_CLEAR = 10'h120;

    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_CMD   = 2'd1,
        PH_WRITE = 2'd2,
        PH_READ  = 2'd3
    } phase_t;

    typedef struct packed {
        phase_t             kind;
        logic               wfr;
        logic               lc;
        logic               iwc;
        logic [LEN_W-1:0]   low;
    } op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_STROBE,
        S_RECOVER,
        S_SETTLE,
        S_RDY,
        S_DONE,
        S_ABORT
    } seq_state_t;

endpackage

// File: rtl/nseq_fifo.sv
`timescale 1ns/1ps
module nseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CAP);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

endmodule

// File: rtl/nseq_status.sv
`timescale 1ns/1ps
module nseq_status
    import nseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] level_i,
    input  logic              clr_i,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic              irq_set,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] sticky;
    logic [STAT_W-1:0] wipe;
    logic              irq_q;

    assign wipe = clr_i ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= '0;
            irq_q  <= 1'b0;
        end else begin
            sticky <= (sticky & ~wipe) | set_i;
            irq_q  <= (irq_q & ~wipe[ST_DONE]) | irq_set;
        end
    end

    assign status_o = sticky | level_i;
    assign irq_o    = irq_q;

endmodule

// File: rtl/nseq_engine.sv
`timescale 1ns/1ps
module nseq_engine
    import nseq_pkg::*;
#(
    parameter int T_LO   = 3,
    parameter int T_HI   = 2,
    parameter int T_WB   = 4,
    parameter int TX_TMO = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  op_t        op_in,
    output logic       op_take,
    input  logic       tx_empty,
    input  logic [7:0] tx_byte,
    output logic       tx_take,
    input  logic       rx_full,
    output logic       rx_put,
    output logic [7:0] rx_byte,
    input  logic [7:0] dq_in,
    input  logic       rb_ready,
    output logic       ce_n,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       done_p,
    output logic       irq_p,
    output logic       tmo_p,
    output logic       xfer_p,
    output logic       rxovf_p,
    output logic       data_req
);
    localparam int MAX_A = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int MAX_B = (T_WB > TX_TMO) ? T_WB : TX_TMO;
    localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LO_END  = CW'(T_LO - 1);
    localparam logic [CW-1:0] HI_END  = CW'(T_HI - 1);
    localparam logic [CW-1:0] WB_END  = CW'(T_WB - 1);
    localparam logic [CW-1:0] TMO_END = CW'(TX_TMO - 1);

    seq_state_t       state, nxt;
    op_t              op;
    logic [LEN_W-1:0] remain;
    logic [CW-1:0]    cnt;
    logic             ce_act;
    logic [7:0]       dq_q;
    logic             is_data, is_read, on_bus;

    assign is_data = (op.kind == PH_WRITE) || (op.kind == PH_READ);
    assign is_read = (op.kind == PH_READ);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (op_valid) nxt = S_LOAD;
            S_LOAD: begin
                if (op.kind != PH_WRITE)  nxt = S_STROBE;
                else if (!tx_empty)       nxt = S_STROBE;
                else if (cnt == TMO_END)  nxt = S_ABORT;
            end
            S_STROBE:  if (cnt == LO_END) nxt = S_RECOVER;
            S_RECOVER: begin
                if (cnt == HI_END) begin
                    if (is_data && remain != '0) nxt = S_LOAD;
                    else if (op.wfr)             nxt = S_SETTLE;
                    else                         nxt = S_DONE;
                end
            end
            S_SETTLE:  if (cnt == WB_END) nxt = S_RDY;
            S_RDY:     if (rb_ready) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            S_ABORT:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register and phase datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op     <= '0;
            remain <= '0;
            cnt    <= '0;
            ce_act <= 1'b0;
            dq_q   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) cnt <= '0;
            else              cnt <= cnt + 1'b1;
            unique case (state)
                S_IDLE: if (op_valid) begin
                    op     <= op_in;
                    remain <= op_in.low;
                    dq_q   <= op_in.low[7:0];
                    ce_act <= 1'b1;
                end
                S_LOAD:    if (op.kind == PH_WRITE && !tx_empty) dq_q <= tx_byte;
                S_RECOVER: if (cnt == HI_END && is_data && remain != '0) remain <= remain - 1'b1;
                S_DONE:    if (op.lc) ce_act <= 1'b0;
                S_ABORT:   ce_act <= 1'b0;
                default:   ;
            endcase
        end
    end

    // outputs
    always_comb begin
        on_bus   = (state == S_LOAD) || (state == S_STROBE) || (state == S_RECOVER);
        op_take  = (state == S_IDLE) && op_valid;
        tx_take  = (state == S_LOAD) && (op.kind == PH_WRITE) && !tx_empty;
        rx_put   = (state == S_STROBE) && is_read && (cnt == LO_END) && !rx_full;
        rxovf_p  = (state == S_STROBE) && is_read && (cnt == LO_END) && rx_full;
        rx_byte  = dq_in;
        ce_n     = !ce_act;
        cle      = on_bus && (op.kind == PH_CMD);
        ale      = on_bus && (op.kind == PH_ADDR);
        we_n     = !((state == S_STROBE) && !is_read);
        re_n     = !((state == S_STROBE) && is_read);
        dq_out   = dq_q;
        dq_oe    = on_bus && !is_read;
        done_p   = (state == S_DONE);
        irq_p    = (state == S_DONE) && op.iwc;
        xfer_p   = (state == S_DONE) && is_data;
        tmo_p    = (state == S_ABORT);
        data_req = (state == S_LOAD) && (op.kind == PH_WRITE) && tx_empty;
    end

endmodule

// File: rtl/nand_op_seq.sv
`timescale 1ns/1ps
module nand_op_seq
    import nseq_pkg::*;
#(
    parameter int T_LO       = 3,
    parameter int T_HI       = 2,
    parameter int T_WB       = 4,
    parameter int TX_TMO     = 20,
    parameter int CMD_DEPTH  = 8,
    parameter int BYTE_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [9:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [15:0] int_status,
    output logic        irq,
    input  logic        tx_push,
    input  logic [7:0]  tx_data,
    output logic        tx_full,
    input  logic        rx_pop,
    output logic [7:0]  rx_data,
    output logic        rx_empty,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rb_n
);
    localparam int OP_W = $bits(op_t);

    op_t        op_new, op_head;
    logic       q_push, q_pop, q_full, q_empty;
    logic       tx_empty, tx_take, rx_full, rx_put;
    logic [7:0] tx_head, rx_byte;
    logic [1:0] rb_sync;
    logic       done_p, irq_p, tmo_p, xfer_p, rxovf_p, data_req;
    logic       clr_hit;
    logic [STAT_W-1:0] set_v, level_v;
    logic       unused_bits;

    assign q_push  = reg_we && (reg_addr == OFS_QUEUE);
    assign clr_hit = reg_we && (reg_addr == OFS_CLEAR);

    assign op_new.kind = phase_t'(reg_wdata[TYPE_LSB +: 2]);
    assign op_new.wfr  = reg_wdata[BIT_WFR];
    assign op_new.lc   = reg_wdata[BIT_LC];
    assign op_new.iwc  = reg_wdata[BIT_IWC];
    assign op_new.low  = reg_wdata[LEN_W-1:0];
    assign unused_bits = ^{reg_wdata[31:20], reg_wdata[15:14], reg_wdata[12]};

    nseq_fifo #(.W(OP_W), .DEPTH(CMD_DEPTH)) u_opq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(op_new),
        .pop(q_pop), .rdata(op_head), .full(q_full), .empty(q_empty)
    );

    nseq_fifo #(.W(8), .DEPTH(BYTE_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
        .pop(tx_take), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    nseq_fifo #(.W(8), .DEPTH(BYTE_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_put), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_sync <= 2'b00;
        else        rb_sync <= {rb_sync[0], nand_rb_n};
    end

    nseq_engine #(.T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB), .TX_TMO(TX_TMO)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .op_valid(!q_empty), .op_in(op_head), .op_take(q_pop),
        .tx_empty(tx_empty), .tx_byte(tx_head), .tx_take(tx_take),
        .rx_full(rx_full), .rx_put(rx_put), .rx_byte(rx_byte),
        .dq_in(nand_dq_in), .rb_ready(rb_sync[1]),
        .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
        .done_p(done_p), .irq_p(irq_p), .tmo_p(tmo_p),
        .xfer_p(xfer_p), .rxovf_p(rxovf_p), .data_req(data_req)
    );

    always_comb begin
        set_v           = '0;
        set_v[ST_TXUF]  = tmo_p;
        set_v[ST_TXOF]  = tx_push && tx_full;
        set_v[ST_RXUF]  = rx_pop && rx_empty;
        set_v[ST_RXOF]  = rxovf_p;
        set_v[ST_DONE]  = done_p;
        set_v[ST_ERR]   = tmo_p || (q_push && q_full);
        set_v[ST_XOVER] = xfer_p;
        level_v         = '0;
        level_v[ST_DREQ] = data_req;
        level_v[ST_DAV]  = !rx_empty;
        level_v[ST_CAV]  = !q_empty;
    end

    nseq_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(set_v), .level_i(level_v),
        .clr_i(clr_hit), .clr_mask(reg_wdata[STAT_W-1:0]),
        .irq_set(irq_p), .status_o(int_status), .irq_o(irq)
    );

endmodule

// File: rtl/nseq_checker.sv
`timescale 1ns/1ps
module nseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [9:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [15:0] int_status,
    input logic        irq,
    input logic        nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic [7:0]  nand_dq_out,
    input logic        nand_dq_oe
);
    a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    a_r9_strobe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    a_r4_bus_steady_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

    a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_status[9]);

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[9] && !(reg_we && reg_addr == 10'h120 && reg_wdata[9])) |=> int_status[9]);

    a_r13_avail_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 10'h000) |=> int_status[10]);
endmodule

bind nand_op_seq nseq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .int_status(int_status), .irq(irq),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
);

// File: tb/sim_nand_op_seq.sv
`timescale 1ns/1ps
module sim_nand_op_seq;
    localparam int T_LO = 3, T_HI = 2, T_WB = 4, TX_TMO = 20, CMDD = 8, BYTD = 4;

    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [15:0] int_status;
    logic        irq, tx_push = 0, tx_full, rx_pop = 0, rx_empty;
    logic [7:0]  tx_data = '0, rx_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb_n = 1;

    nand_op_seq #(.T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB), .TX_TMO(TX_TMO),
                  .CMD_DEPTH(CMDD), .BYTE_DEPTH(BYTD)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, failures = 0, ended = 0;
    int we_low = 0, re_low = 0, rd_idx = 0, rec_cnt = 0, exp_cnt = 0, bad_width = 0;
    logic [9:0] cap, rec [256], expv [256];

    function automatic logic [7:0] pat(input int i);
        return 8'hA5 ^ 8'(i * 29);
    endfunction
    function automatic logic [31:0] mk(input logic [1:0] ty, input logic wfr, lc, iwc,
                                       input logic [11:0] low);
        return {12'b0, wfr, lc, ty, 2'b0, iwc, 1'b0, low};
    endfunction

    assign nand_dq_in = pat(rd_idx);

    // bus monitor and flash responder
    always @(negedge clk) begin
        if (!nand_we_n) begin
            we_low++; cap = {nand_cle, nand_ale, nand_dq_out};
        end else if (we_low > 0) begin
            if (we_low != T_LO) bad_width++;
            rec[rec_cnt[7:0]] = cap; rec_cnt++; we_low = 0;
        end
        if (!nand_re_n) re_low++;
        else if (re_low > 0) begin rd_idx++; re_low = 0; end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d; tick(1); reg_we = 0;
    endtask
    task automatic txb(input logic [7:0] b);
        tx_push = 1; tx_data = b; tick(1); tx_push = 0;
    endtask
    task automatic wait_done();
        for (int n = 0; n < 600 && !int_status[9]; n++) tick(1);
    endtask
    task automatic expect_ent(input logic [1:0] k, input logic [7:0] b);
        expv[exp_cnt[7:0]] = {k, b}; exp_cnt++;
    endtask
    task automatic compare(input string req);
        int bad = 0;
        check(rec_cnt == exp_cnt, req, rec_cnt, exp_cnt);
        for (int i = 0; i < exp_cnt && i < rec_cnt; i++)
            if (rec[i] != expv[i] && bad == 0) begin
                bad = 1; check(0, req, rec[i], expv[i]);
            end
        if (bad == 0) check(1, req, 0, 0);
        rec_cnt = 0; exp_cnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (ended == 0) begin
            failures++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        tick(3); rst_n = 1; tick(1);
        // R1 reset state
        check(int_status == 0 && irq == 0, "R1 status", int_status, 0);
        check({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale} == 5'b11100, "R1 pins",
              {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);

        // R7 exact completion window, R8 irq, R9 CE held, R2 command latch
        wr(10'h000, mk(2'd1, 0, 0, 1, 12'h0FF));
        tick(2 + T_LO + T_HI);
        check(int_status[9] == 0, "R7 early", int_status[9], 0);
        tick(1);
        check(int_status[9] == 1, "R7 due", int_status[9], 1);
        check(irq == 1, "R8 irq raised", irq, 1);
        check(nand_ce_n == 0, "R9 ce held", nand_ce_n, 0);
        expect_ent(2'b10, 8'hFF); tick(2); compare("R2 command latch");
        wr(10'h120, 32'h200);
        check(int_status[9] == 0 && irq == 0, "R7 R8 clear", {int_status[9], irq}, 0);

        // R3 address, R9 release on last cycle
        wr(10'h000, mk(2'd0, 0, 1, 0, 12'h03C)); wait_done(); tick(1);
        expect_ent(2'b01, 8'h3C); compare("R3 address latch");
        check(nand_ce_n == 1, "R9 ce released", nand_ce_n, 1);
        wr(10'h120, 32'hFFFF);

        // R4 write burst, R5 transfer-over bit
        txb(8'h11); txb(8'h22); txb(8'h33);
        wr(10'h000, mk(2'd2, 0, 1, 0, 12'd2)); wait_done(); tick(1);
        expect_ent(2'b00, 8'h11); expect_ent(2'b00, 8'h22); expect_ent(2'b00, 8'h33);
        compare("R4 write burst");
        check(int_status[12] == 1, "R5 xfer over", int_status[12], 1);
        wr(10'h120, 32'hFFFF);

        // R5 read burst
        rd_idx = 0;
        wr(10'h000, mk(2'd3, 0, 1, 0, 12'd2)); wait_done(); tick(1);
        check(int_status[3] == 1, "R5 data avail", int_status[3], 1);
        for (int i = 0; i < 3; i++) begin
            check(rx_data == pat(i), "R5 read byte", rx_data, pat(i));
            rx_pop = 1; tick(1); rx_pop = 0;
        end
        check(int_status[3] == 0, "R5 drained", int_status[3], 0);
        wr(10'h120, 32'hFFFF);

        // R12 receive overflow and underflow
        rd_idx = 0;
        wr(10'h000, mk(2'd3, 0, 1, 0, 12'd5)); wait_done(); tick(1);
        check(int_status[5] == 1, "R12 rx overflow", int_status[5], 1);
        for (int i = 0; i < BYTD; i++) begin
            check(rx_data == pat(i), "R12 rx kept", rx_data, pat(i));
            rx_pop = 1; tick(1); rx_pop = 0;
        end
        check(int_status[4] == 0, "R12 no underflow yet", int_status[4], 0);
        rx_pop = 1; tick(1); rx_pop = 0;
        check(int_status[4] == 1, "R12 rx underflow", int_status[4], 1);
        wr(10'h120, 32'hFFFF);

        // R12 transmit overflow drops the extra byte
        for (int i = 0; i < BYTD + 1; i++) txb(8'h40 + 8'(i));
        check(int_status[2] == 1, "R12 tx overflow", int_status[2], 1);
        wr(10'h000, mk(2'd2, 0, 1, 0, 12'd3)); wait_done(); tick(1);
        for (int i = 0; i < BYTD; i++) expect_ent(2'b00, 8'h40 + 8'(i));
        compare("R12 tx kept");
        wr(10'h120, 32'hFFFF);

        // R11 starved write, R13 data required
        wr(10'h000, mk(2'd2, 0, 0, 0, 12'd0)); tick(5);
        check(int_status[0] == 1, "R13 data required", int_status[0], 1);
        tick(TX_TMO + 10);
        check(int_status[11] && int_status[1], "R11 error bits", int_status, 16'h0802);
        check(int_status[9] == 0, "R11 no done", int_status[9], 0);
        check(nand_ce_n == 1 && rec_cnt == 0, "R11 discarded", rec_cnt, 0);
        wr(10'h120, 32'hFFFF);

        // R6 ready gating, R10 queue depth, R14 order, R13 available
        nand_rb_n = 0;
        wr(10'h000, mk(2'd1, 1, 0, 0, 12'h070)); tick(40);
        check(int_status[9] == 0, "R6 held busy", int_status[9], 0);
        expect_ent(2'b10, 8'h70);
        for (int i = 0; i < CMDD; i++) begin
            wr(10'h000, mk(2'd0, 0, 0, 0, 12'(8'h80 + i)));
            expect_ent(2'b01, 8'(8'h80 + i));
        end
        check(int_status[10] == 1, "R13 cmd available", int_status[10], 1);
        check(int_status[11] == 0, "R10 not yet full", int_status[11], 0);
        wr(10'h000, mk(2'd0, 0, 1, 0, 12'h0EE));
        check(int_status[11] == 1, "R10 full push", int_status[11], 1);
        nand_rb_n = 1; wait_done();
        check(int_status[9] == 1, "R6 done on ready", int_status[9], 1);
        tick(200);
        compare("R10 R14 order");
        wr(10'h120, 32'hFFFF);

        // random phases: R2 R3 R4 R14
        for (int it = 0; it < 24; it++) begin
            int ty = $urandom % 3;
            logic lc = 1'($urandom);
            logic wfr = 1'($urandom);
            logic [7:0] b = 8'($urandom);
            if (ty == 2) begin
                int len = 1 + $urandom % BYTD;
                for (int k = 0; k < len; k++) begin
                    logic [7:0] d = 8'($urandom);
                    txb(d); expect_ent(2'b00, d);
                end
                wr(10'h000, mk(2'd2, wfr, lc, 0, 12'(len - 1)));
            end else begin
                expect_ent(ty == 1 ? 2'b10 : 2'b01, b);
                wr(10'h000, mk(2'(ty), wfr, lc, 0, {4'h0, b}));
            end
            wait_done(); tick(1);
            compare("R14 random phase");
            check(nand_ce_n == lc, "R9 random ce", nand_ce_n, lc);
            wr(10'h120, 32'hFFFF);
        end
        check(bad_width == 0, "R2 strobe width", bad_width, 0);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule